// File: doc/BRIEF.md
# Timer Counter with Capture/Compare Register

This block is an up-counter paired with one capture/compare register. The counter advances by one on each cycle in which the count-enable input is high, provided a run mode is selected. A 2-bit mode field chooses among four behaviours. Stop holds the count at zero. Free running counts and wraps. Edge restart clears the count on a selected edge of an external input. Match restart clears the count when it equals the compare value. A separate one-shot enable lets software restart the count by writing a trigger.

A control bit sets the register's role. In compare use it is checked against the count every cycle, and a single-cycle interrupt pulse marks each new match. In capture use a selected edge of the external input copies the running count into it. Software uses a valid/ready request channel and a valid/ready response channel. Only one read can be outstanding. While a counter read is in flight, counting is paused. Enables that arrive during the pause are held and applied afterwards, so none are lost, and the value returned is the count at the moment of the read.

Register addresses (req_addr): 0 = count (read-only, writes ignored), 1 = capture/compare value, 2 = control, 3 = one-shot trigger (write-only, reads return 0). Control layout: bits[1:0] mode (00 stop, 01 free run, 10 edge restart, 11 match restart), bits[3:2] edge select, bit 4 capture use (0 = compare), bit 5 one-shot enable.

Top module: `cc_timer`

## Requirements
- R1: In modes 01, 10 and 11, each clock edge with cnt_en high and no clear adds one to the count, wrapping from all-ones to zero. A bus write to address 0 has no effect on the count.
- R2: A read of address 0 returns the count at acceptance. No count change occurs from acceptance until the response handshake. Enables seen during that window (up to 2^HOLD_W-1 of them) are applied afterwards, one per cycle.
- R3: In mode 00 the count is zero one cycle later and stays zero. Held enables are discarded.
- R4: In mode 10, a selected edge on ext_in clears the count. The edge passes through a SYNC_STAGES-flop synchronizer, so the clear lands on the (SYNC_STAGES+1)-th clock edge after the pin changes.
- R5: Edge select bits[3:2]: 00 none, 01 rising, 10 falling, 11 both. With 00, no edge ever clears or captures.
- R6: In mode 11 with compare use, a count equal to the register value is cleared to zero at the next clock edge.
- R7: A write to address 3 with bit 0 set clears the count at acceptance only when control bit 5 is 1 and the mode is not 00. Otherwise the write has no effect.
- R8: The capture/compare register resets to zero, is written at address 1 and reads back at address 1.
- R9: In capture use, a selected edge latches the count into the register. If a bus write to address 1 is accepted on the same edge, the capture wins.
- R10: In compare use with a run mode, match_irq goes high for exactly one cycle, one cycle after the count first equals the register value. There is one pulse per match event and none in capture use.
- R11: A clear from any source takes priority over a count enable in the same cycle.
- R12: Reading the count leaves the capture/compare register unchanged.
- R13: req_ready is low while a response is pending. rsp_valid and rsp_data stay stable until rsp_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable, one count per high cycle |
| ext_in | input | 1 | Asynchronous external timer input |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register address |
| req_wdata | input | W | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accepted |
| rsp_data | output | W | Read response data |
| match_irq | output | 1 | One-cycle compare-match interrupt pulse |

## Verification
The bench builds the block with W = 8, HOLD_W = 2 and SYNC_STAGES = 2. The 8-bit count brings wraparound within a few hundred cycles. The 2-bit hold counter can be filled during a single stalled read response. The synchronizer depth of two fixes the edge-to-clear latency at three clock edges, which the bench uses to land a capture and a bus write on the same edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_STOP  = 2'b00,
    MODE_FREE  = 2'b01,
    MODE_EDGE  = 2'b10,
    MODE_MATCH = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic      oneshot_en;
    logic      cap_use;
    edge_sel_e edge_sel;
    tmr_mode_e mode;
  } tmr_ctrl_t;

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_CR   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_SHOT = 2'd3;

endpackage

// File: rtl/tmr_edge.sv
module tmr_edge
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin,
  input  edge_sel_e sel,
  output logic      edge_o
);

  // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] chain;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-1:0], pin};
  end

  assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  assign fall = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];

  always_comb begin
    unique case (sel)
      EDGE_RISE: edge_o = rise;
      EDGE_FALL: edge_o = fall;
      EDGE_BOTH: edge_o = rise | fall;
      default:   edge_o = 1'b0;
    endcase
  end

  assert_none_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == EDGE_NONE) |-> !edge_o);

endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int W      = 16,
  parameter int HOLD_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tmr_mode_e     mode,
  input  logic          cnt_en,
  input  logic          pause,
  input  logic          clr_edge,
  input  logic          clr_match,
  input  logic          clr_shot,
  output logic [W-1:0]  count
);

  localparam logic [HOLD_W-1:0] HOLD_MAX = {HOLD_W{1'b1}};

  logic [HOLD_W-1:0] held, held_d;
  logic stop, clr, tick;

  assign stop = (mode == MODE_STOP);
  assign clr  = stop | clr_edge | clr_match | clr_shot;
  assign tick = !pause && !stop && (cnt_en || held != '0);

  always_comb begin
    held_d = held;
    if (stop)                                       held_d = '0;
    else if (cnt_en && !tick && held != HOLD_MAX)   held_d = held + 1'b1;
    else if (!cnt_en && tick)                       held_d = held - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      held  <= '0;
    end else begin
      held <= held_d;
      if (clr)       count <= '0;
      else if (tick) count <= count + 1'b1;
    end
  end

  assert_stop_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (count == '0));

  assert_pause_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !clr) |=> $stable(count));

  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && cnt_en) |=> (count == '0));

  assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count == $past(count) || count == $past(count) + 1'b1));

endmodule

// File: rtl/tmr_ccr.sv
module tmr_ccr #(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  count,
  input  logic          run,
  input  logic          cap_use,
  input  logic          cap_edge,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  cr,
  output logic          hit,
  output logic          irq
);

  logic hit_q;

  assign hit = run && !cap_use && (count == cr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr    <= '0;
      hit_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (cap_use && cap_edge) cr <= count;
      else if (wr_en)          cr <= wr_data;
      hit_q <= hit;
      irq   <= hit && !hit_q;
    end
  end

  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_no_irq_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_use && $past(cap_use)) |-> !irq);

  assert_capture_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_use && cap_edge) |=> (cr == $past(count)));

endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import tmr_pkg::*;
#(
  parameter int W           = 16,
  parameter int HOLD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          ext_in,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_addr,
  input  logic [W-1:0]  req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [W-1:0]  rsp_data,
  output logic          match_irq
);

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  tmr_ctrl_t    ctrl_q;
  logic         rsp_cnt_q;
  logic [W-1:0] count, cr, rd_mux;
  logic         edge_pulse, hit;
  logic         acc, wr, rd, pause, run;
  logic         clr_edge, clr_match, clr_shot;

  assign req_ready = !rsp_valid;
  assign acc       = req_valid && req_ready;
  assign wr        = acc && req_write;
  assign rd        = acc && !req_write;
  assign run       = (ctrl_q.mode != MODE_STOP);

  assign clr_shot  = wr && (req_addr == ADDR_SHOT) && req_wdata[0]
                     && ctrl_q.oneshot_en && run;
  assign clr_edge  = (ctrl_q.mode == MODE_EDGE) && edge_pulse;
  assign clr_match = (ctrl_q.mode == MODE_MATCH) && hit;
  assign pause     = rsp_cnt_q || (rd && (req_addr == ADDR_CNT));

  tmr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin    (ext_in),
    .sel    (ctrl_q.edge_sel),
    .edge_o (edge_pulse)
  );

  tmr_count #(.W(W), .HOLD_W(HOLD_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (ctrl_q.mode),
    .cnt_en    (cnt_en),
    .pause     (pause),
    .clr_edge  (clr_edge),
    .clr_match (clr_match),
    .clr_shot  (clr_shot),
    .count     (count)
  );

  tmr_ccr #(.W(W)) u_ccr (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (count),
    .run      (run),
    .cap_use  (ctrl_q.cap_use),
    .cap_edge (edge_pulse),
    .wr_en    (wr && (req_addr == ADDR_CR)),
    .wr_data  (req_wdata),
    .cr       (cr),
    .hit      (hit),
    .irq      (match_irq)
  );

  always_comb begin
    unique case (req_addr)
      ADDR_CNT:  rd_mux = count;
      ADDR_CR:   rd_mux = cr;
      ADDR_CTRL: rd_mux = W'(ctrl_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= tmr_ctrl_t'('0);
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_cnt_q <= 1'b0;
    end else begin
      if (wr && (req_addr == ADDR_CTRL))
        ctrl_q <= tmr_ctrl_t'(req_wdata[CTRL_W-1:0]);
      if (rd) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_mux;
        rsp_cnt_q <= (req_addr == ADDR_CNT);
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
        rsp_cnt_q <= 1'b0;
      end
    end
  end

  assert_rsp_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_one_outstanding_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_read_keeps_cr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && req_addr == ADDR_CNT && !edge_pulse) |=> $stable(cr));

endmodule

// File: tb/sim_cc_timer.sv
module sim_cc_timer;
  localparam int W  = 8;
  localparam int HW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         cnt_en = 1'b0, ext_in = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [1:0]   req_addr = 2'd0;
  logic [W-1:0] req_wdata = '0;
  logic         rsp_valid, rsp_ready = 1'b1;
  logic [W-1:0] rsp_data;
  logic         match_irq;

  int n_checks = 0, n_fail = 0, n_irq = 0, base = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  cc_timer #(.W(W), .HOLD_W(HW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ext_in(ext_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .match_irq(match_irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each response handshake, counts irq pulses
  initial begin
    forever begin
      @(negedge clk); #1;
      if (match_irq) n_irq++;
      if (rsp_valid && rsp_ready) begin
        logic [W-1:0] e;
        string t;
        if (exp_q.size() == 0) check("R13 unexpected response", 1, 0);
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, int'(rsp_data), int'(e));
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = W'(d);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic issue_rd(input logic [1:0] a, input int e, input string tag);
    exp_q.push_back(W'(e));
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input int e, input string tag);
    issue_rd(a, e, tag);
    while (rsp_valid) @(negedge clk);
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R13 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R13 req_ready after reset", int'(req_ready), 1);
    check("R10 no irq after reset", int'(match_irq), 0);
    rd(2'd0, 0, "R3 count zero after reset");
    rd(2'd1, 0, "R8 register zero after reset");

    // stop mode ignores enables
    tick(5);
    rd(2'd0, 0, "R3 stop mode holds zero");

    // free running and wrap
    wr(2'd2, 8'h01);
    tick(10);
    rd(2'd0, 10, "R1 free-run count");
    tick(250);
    rd(2'd0, 4, "R1 wrap past all-ones");

    // stalled counter read: pause and held enables
    @(negedge clk) rsp_ready = 1'b0;
    issue_rd(2'd0, 4, "R2 read value at acceptance");
    check("R13 req_ready low while pending", int'(req_ready), 0);
    tick(3);
    check("R13 rsp_valid held", int'(rsp_valid), 1);
    check("R13 rsp_data held", int'(rsp_data), 4);
    @(negedge clk) rsp_ready = 1'b1;
    idle(6);
    rd(2'd0, 7, "R2 held enables applied after read");

    // edge restart, rising edges only
    wr(2'd2, 8'h06);
    @(negedge clk) ext_in = 1'b1;
    idle(5);
    rd(2'd0, 0, "R4 rising edge clears count");
    tick(5);
    @(negedge clk) ext_in = 1'b0;
    idle(5);
    rd(2'd0, 5, "R5 falling edge ignored in rising select");
    wr(2'd2, 8'h0E);
    @(negedge clk) ext_in = 1'b1;
    idle(5);
    rd(2'd0, 0, "R5 both-edge select clears");
    wr(2'd2, 8'h02);
    tick(3);
    @(negedge clk) ext_in = 1'b0;
    idle(5);
    rd(2'd0, 3, "R5 select none never clears");

    // match restart
    wr(2'd1, 20);
    rd(2'd1, 20, "R8 register readback");
    wr(2'd2, 8'h03);
    base = n_irq;
    tick(17);
    @(negedge clk);
    check("R10 irq one cycle after match", int'(match_irq), 1);
    @(negedge clk);
    check("R10 irq single cycle", int'(match_irq), 0);
    rd(2'd0, 0, "R6 match clears count");
    tick(25);
    rd(2'd0, 4, "R11 clear beats count enable");
    check("R10 irq once per match event", n_irq - base, 2);

    // capture use
    wr(2'd2, 8'h15);
    base = n_irq;
    tick(6);
    @(negedge clk) ext_in = 1'b1;
    idle(5);
    rd(2'd1, 10, "R9 edge captures count");
    rd(2'd0, 10, "R9 free run not cleared by capture");
    check("R10 no irq in capture use", n_irq - base, 0);
    tick(5);
    @(negedge clk) ext_in = 1'b0;
    idle(5);
    @(negedge clk) ext_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 2'd1; req_wdata = 8'd99;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd(2'd1, 15, "R9 capture wins over same-edge write");

    // one-shot trigger
    wr(2'd2, 8'h01);
    wr(2'd3, 1);
    rd(2'd0, 15, "R7 trigger ignored when disabled");
    wr(2'd2, 8'h21);
    wr(2'd3, 1);
    rd(2'd0, 0, "R7 trigger clears count");

    // read-only counter, read does not touch register
    tick(9);
    wr(2'd0, 77);
    rd(2'd0, 9, "R1 write to count ignored");
    rd(2'd1, 15, "R12 count read leaves register");
    rd(2'd2, 8'h21, "R8 control readback");

    // back to stop
    wr(2'd2, 8'h00);
    rd(2'd0, 0, "R3 stop clears count");
    tick(4);
    rd(2'd0, 0, "R3 stop ignores enables");

    idle(2);
    check("R13 all responses returned", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule